// File: doc/BRIEF.md
# 8x8 Transpose Buffer Between Row and Column DCT Passes

This block is the intermediate store of a two-pass 2-D DCT. The row pass delivers one 16-bit coefficient per accepted cycle, eight rows of eight values per block. The column pass takes the same coefficients back out in transposed order: the first eight values it receives are column 0 of the block, the next eight are column 1, and so on. One 64-entry array serves both sides. A write and a read can happen in the same cycle, so the two passes run at the same time without a second bank.

To allow this, the addressing pattern alternates from block to block. An even block is written with address row*8+col and read with col*8+row. An odd block uses the opposite pair. In either case the reader of block k visits the locations in the same order that the writer of block k+1 fills them. Each location is therefore freed just as the next block needs it. Handshakes on both sides stall the writer when all 64 entries hold unread data, and hold off the reader until a whole block is present.

Top module: `xpose_buf`

## Requirements
- R1: A synchronous active-high reset clears both stream positions and the order alternation. In the cycle after reset, `rd_valid` is 0 and `wr_ready` is 1.
- R2: A write is accepted when `wr_valid` and `wr_ready` are both 1. `rd_valid` first goes to 1 in the cycle after the 64th accepted write of a block.
- R3: `rd_valid` is 1 exactly when at least one fully written block has not been fully read. It is 0 otherwise, including while a later block is only partly written.
- R4: Number the values of each block by the order in which they were accepted, p = row*8+col. The q-th read of the same block (q = 0..63) returns the value with p = (q mod 8)*8 + (q div 8). This holds for even and odd blocks alike.
- R5: `wr_ready` is 0 when 64 entries hold unread data and no read fires in the same cycle. It is 1 otherwise. When the store is full, a read firing in a cycle permits a write in that same cycle, and the read returns the old value (read before write).
- R6: A write presented while `wr_ready` is 0 is ignored: no entry changes and the write position does not advance.
- R7: A read request presented while `rd_valid` is 0 is ignored: the read position does not advance.
- R8: A reset applied mid-stream discards all held data. Afterwards the buffer reports empty and ready for writing.
- R9: With `wr_valid` and `rd_ready` held at 1, after the first block the buffer passes one value per cycle indefinitely. `wr_ready` stays 1 and each block comes out correctly transposed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Writer presents a coefficient |
| wr_data | input | 16 | Coefficient from the row pass |
| wr_ready | output | 1 | Buffer can take the coefficient this cycle |
| rd_ready | input | 1 | Reader takes a coefficient this cycle if one is valid |
| rd_valid | output | 1 | A complete block is available to read |
| rd_data | output | 16 | Transposed coefficient for the column pass |

## Verification
The bench first applies directed patterns:
- Single blocks are written with no reader, which shows that `rd_valid` waits for the 64th write.
- Writes are held against a full store, which shows that stalled writes leave nothing behind.
- A read request is made on an empty buffer.

Constrained random phases then vary how often the writer and the reader are active. Frequent writes keep the buffer near full and exercise the same-cycle read/write release. Sparse writes keep it near empty and exercise the partial-block `rd_valid` rule. Continuous streaming runs through several even and odd blocks, which separates a correct order alternation from one that only transposes every second block. A reference model predicts every flag and every read value.

// File: rtl/xpose_pkg.sv
package xpose_pkg;

    // Number of bits used to count whole blocks; two bits tell apart
    // "reader and writer on the same block" from "writer one block ahead".
    localparam int BLK_W = 2;

    // Walking pattern through the square array.
    typedef enum logic {
        ORD_ROW = 1'b0,   // address = position
        ORD_COL = 1'b1    // address = position with its halves swapped
    } order_e;

    // Writer uses row order on even blocks; reader uses the other one.
    function automatic order_e pick_order(input logic blk_lsb, input logic is_reader);
        return order_e'(blk_lsb ^ is_reader);
    endfunction

endpackage

// File: rtl/xpose_seq.sv
module xpose_seq #(
    parameter int POS_W = 6,
    parameter int BLK_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [POS_W-1:0] pos,
    output logic [BLK_W-1:0] blk
);
    // Position inside the block and block number form one counter, so the
    // block number steps exactly when the position wraps.
    always_ff @(posedge clk) begin
        if (rst) begin
            {blk, pos} <= '0;
        end else if (adv) begin
            {blk, pos} <= {blk, pos} + 1'b1;
        end
    end
endmodule

// File: rtl/xpose_addr.sv
module xpose_addr
    import xpose_pkg::*;
#(
    parameter int HALF = 3
) (
    input  logic [2*HALF-1:0] pos,
    input  order_e            ord,
    output logic [2*HALF-1:0] addr
);
    always_comb begin
        if (ord == ORD_COL) begin
            addr = {pos[HALF-1:0], pos[2*HALF-1:HALF]};
        end else begin
            addr = pos;
        end
    end
endmodule

// File: rtl/xpose_store.sv
module xpose_store #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    // Combinational read port: a same-address write lands only at the edge,
    // so the read sees the previous content.
    assign rdata = cells[raddr];
endmodule

// File: rtl/xpose_buf.sv
module xpose_buf
    import xpose_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int SIDE_LOG2 = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              rd_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    localparam int POS_W = 2 * SIDE_LOG2;

    logic [POS_W-1:0] w_pos, r_pos, w_addr, r_addr;
    logic [BLK_W-1:0] w_blk, r_blk;
    logic             full;
    logic             wr_fire, rd_fire;
    order_e           w_ord, r_ord;

    // A whole block is pending whenever the block numbers differ.
    assign rd_valid = (w_blk != r_blk);
    // Writer a full block ahead, sitting on the location the reader still needs.
    assign full     = rd_valid && (w_pos == r_pos);
    assign wr_ready = !full || rd_ready;
    assign wr_fire  = wr_valid && wr_ready;
    assign rd_fire  = rd_ready && rd_valid;

    assign w_ord = pick_order(w_blk[0], 1'b0);
    assign r_ord = pick_order(r_blk[0], 1'b1);

    xpose_seq #(.POS_W(POS_W), .BLK_W(BLK_W)) u_wseq (
        .clk(clk), .rst(rst), .adv(wr_fire), .pos(w_pos), .blk(w_blk)
    );

    xpose_seq #(.POS_W(POS_W), .BLK_W(BLK_W)) u_rseq (
        .clk(clk), .rst(rst), .adv(rd_fire), .pos(r_pos), .blk(r_blk)
    );

    xpose_addr #(.HALF(SIDE_LOG2)) u_waddr (
        .pos(w_pos), .ord(w_ord), .addr(w_addr)
    );

    xpose_addr #(.HALF(SIDE_LOG2)) u_raddr (
        .pos(r_pos), .ord(r_ord), .addr(r_addr)
    );

    xpose_store #(.DATA_W(DATA_W), .ADDR_W(POS_W)) u_store (
        .clk(clk), .we(wr_fire), .waddr(w_addr), .wdata(wr_data),
        .raddr(r_addr), .rdata(rd_data)
    );
endmodule

// File: rtl/xpose_chk.sv
module xpose_chk #(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_valid,
    input logic          wr_ready,
    input logic          rd_ready,
    input logic          rd_valid,
    input logic [CW-1:0] w_cnt,
    input logic [CW-1:0] r_cnt
);
    // R1: state right after a reset cycle
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!rd_valid && wr_ready));

    // R6: refused write leaves the write position untouched
    a_r6_no_write_when_full: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> $stable(w_cnt));

    // R7: read request on empty buffer is ignored
    a_r7_no_read_when_empty: assert property (@(posedge clk) disable iff (rst)
        (rd_ready && !rd_valid) |=> $stable(r_cnt));

    // R5: a firing read always frees room for a write
    a_r5_read_frees_slot: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_ready) |-> wr_ready);

    // R3: data becomes available only when the writer has just closed a block
    a_r3_valid_on_block_end: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_valid) |-> (w_cnt[CW-3:0] == '0));
endmodule

bind xpose_buf xpose_chk #(.CW(POS_W + xpose_pkg::BLK_W)) u_chk (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_ready(rd_ready), .rd_valid(rd_valid),
    .w_cnt({w_blk, w_pos}), .r_cnt({r_blk, r_pos})
);

// File: tb/test_xpose_buf.sv
module test_xpose_buf;
    localparam int CLK_P = 10;
    localparam int BLK   = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_valid = 1'b0;
    logic [15:0] wr_data = '0;
    logic        wr_ready;
    logic        rd_ready = 1'b0;
    logic        rd_valid;
    logic [15:0] rd_data;

    xpose_buf i_xpose_buf (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_ready(wr_ready), .rd_ready(rd_ready), .rd_valid(rd_valid),
        .rd_data(rd_data)
    );

    always #(CLK_P/2) clk = ~clk;

    int          n_checks = 0;
    int          n_errors = 0;
    int          nw = 0;
    int          nr = 0;
    logic [15:0] hist [4096];
    string       cur_tag = "R1";
    bit          finished = 1'b0;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", cur_tag, what, act, exp);
        end
    endtask

    // Reference: stream index of the value returned by read number idx
    function automatic int src_index(input int idx);
        int b = idx / BLK;
        int q = idx % BLK;
        return b * BLK + (q % 8) * 8 + (q / 8);
    endfunction

    task automatic step(input bit wv, input logic [15:0] wd, input bit rr);
        bit exp_rv, exp_wr;
        @(negedge clk);
        wr_valid = wv;
        wr_data  = wd;
        rd_ready = rr;
        #(CLK_P/2 - 1);
        exp_rv = (nw / BLK) > (nr / BLK);
        exp_wr = ((nw - nr) < BLK) || (rr && exp_rv);
        chk(rd_valid == exp_rv, "rd_valid", rd_valid, exp_rv);
        chk(wr_ready == exp_wr, "wr_ready", wr_ready, exp_wr);
        if (rr && exp_rv)
            chk(rd_data == hist[src_index(nr)], "rd_data", rd_data, hist[src_index(nr)]);
        @(posedge clk);
        if (wv && exp_wr) begin
            hist[nw] = wd;
            nw++;
        end
        if (rr && exp_rv) nr++;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        wr_valid = 1'b0;
        rd_ready = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        nw = 0;
        nr = 0;
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        // R1: reset state
        cur_tag = "R1";
        do_reset();
        #(CLK_P/2 - 1);
        chk(rd_valid == 1'b0, "rd_valid after reset", rd_valid, 0);
        chk(wr_ready == 1'b1, "wr_ready after reset", wr_ready, 1);

        // R7: read request on an empty buffer
        cur_tag = "R7";
        for (int i = 0; i < 3; i++) step(1'b0, 16'h0, 1'b1);

        // R2: first block, no reader; rd_valid only after the 64th write
        cur_tag = "R2";
        for (int i = 0; i < BLK; i++) step(1'b1, 16'h1000 + 16'(i), 1'b0);

        // R5: full store refuses writes
        cur_tag = "R5";
        for (int i = 0; i < 3; i++) step(1'b0, 16'h0, 1'b0);

        // R6: writes against a full store leave no trace
        cur_tag = "R6";
        for (int i = 0; i < 4; i++) step(1'b1, 16'hDEAD, 1'b0);
        for (int i = 0; i < BLK; i++) step(1'b0, 16'h0, 1'b1);
        step(1'b0, 16'h0, 1'b1);

        // R5: full store, read and write in the same cycle (read before write)
        cur_tag = "R5";
        for (int i = 0; i < BLK; i++) step(1'b1, 16'h2000 + 16'(i), 1'b0);
        for (int i = 0; i < 2 * BLK; i++) step(1'b1, 16'h3000 + 16'(i), 1'b1);

        // R4: random, writer-heavy (near full)
        cur_tag = "R4";
        do_reset();
        for (int i = 0; i < 1500; i++)
            step(($urandom % 100) < 80, 16'($urandom), ($urandom % 100) < 55);

        // R3: random, writer-light (near empty, partial blocks)
        cur_tag = "R3";
        do_reset();
        for (int i = 0; i < 1500; i++)
            step(($urandom % 100) < 35, 16'($urandom), ($urandom % 100) < 80);

        // R9: continuous streaming over many even and odd blocks
        cur_tag = "R9";
        do_reset();
        for (int i = 0; i < 6 * BLK; i++) step(1'b1, 16'($urandom), 1'b1);

        // R8: reset in the middle of a stream
        cur_tag = "R8";
        for (int i = 0; i < 10; i++) step(1'b1, 16'($urandom), 1'b1);
        do_reset();
        #(CLK_P/2 - 1);
        chk(rd_valid == 1'b0, "rd_valid after mid reset", rd_valid, 0);
        chk(wr_ready == 1'b1, "wr_ready after mid reset", wr_ready, 1);
        for (int i = 0; i < BLK + 8; i++) step(1'b1, 16'($urandom), i >= BLK);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule